// File: doc/BRIEF.md
# Round-Robin Ready-List Scheduler

This block decides which task runs. Every runnable task owns a descriptor in memory whose first word is a link to the next runnable descriptor, and the block keeps only two registers of its own: the address of the first waiting descriptor (head) and of the last one (tail). A task is named by its descriptor's word address. The all-ones address is the null link: it marks an empty list and the end of a chain.

The running task gives up the processor in three ways. Its time slice ends after a set number of timer ticks, and it goes to the tail while the head task takes over. It blocks on a communication or a sleep, and is dropped from the list until it is put back in. It ends, and is never put back in. New tasks and woken tasks enter through an enqueue port and are linked at the tail. One enqueue that arrives while the list is being updated is held in a one-entry slot until the pointer writes are done. Memory is reached through a single-port word interface with one cycle of read latency.

Top module: `rr_task_scheduler`

## Requirements
- R1: After reset no task runs (run_valid 0), head_ptr and tail_ptr both hold the all-ones null value, enq_ready is 1 and busy is 0.
- R2: An accepted enqueue of task X writes the null value into word X, then writes X into the word of the old tail (when the list was not empty) and makes X the tail; on an empty list head and tail both become X. Following the links in memory from head_ptr reaches every waiting task in arrival order and ends at the null value.
- R3: When no task runs and the list is not empty, the head task is dispatched: run_id takes the old head, head_ptr takes the word read from the old head's address one cycle after the read request, and tail_ptr becomes null when that word is null.
- R4: When the running task has seen QUANTUM_TICKS ticks and the list is not empty, it is linked at the tail and the head task runs, so tasks rotate in round-robin order.
- R5: When the slice ends with an empty list, the same task keeps running, no memory write happens and the tick count restarts from zero.
- R6: A block request drops the running task without linking it back, and the head task (if any) runs at once without waiting for the slice to end; the new task starts with a tick count of zero.
- R7: A terminate request drops the running task the same way; the task does not appear in the list afterwards.
- R8: Block and terminate requests while no task runs have no effect on run_valid, head_ptr or tail_ptr.
- R9: After an enqueue is accepted enq_ready stays 0 until that task has been linked in; an enqueue that arrives while a slice rotation is under way is linked after the rotated task.
- R10: Ticks that arrive while no task runs are not counted toward the next task's slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timer tick |
| enq_valid | input | 1 | Enqueue request |
| enq_id | input | ADDR_W | Descriptor address of the task to enqueue |
| enq_ready | output | 1 | Enqueue slot is free |
| block_req | input | 1 | Running task blocks |
| term_req | input | 1 | Running task ends |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | ADDR_W | Link word to write |
| mem_rdata | input | ADDR_W | Link word read, valid one cycle after a read request |
| run_valid | output | 1 | A task is running |
| run_id | output | ADDR_W | Address of the running task |
| head_ptr | output | ADDR_W | First waiting task, all ones when empty |
| tail_ptr | output | ADDR_W | Last waiting task, all ones when empty |
| busy | output | 1 | An update is pending or in progress |

## Verification
A wrong head or tail register shows up at the next dispatch as the wrong run_id, and a lost or misplaced link write shows up as soon as the chain in memory is walked from head_ptr, which the bench does after every operation against its own queue model. A tick counter that drifts moves the rotation point by one or more ticks, which the bench sees in the run_id after the tick that should or should not rotate. Errors in the enqueue slot appear as a task missing from, or duplicated in, the walked chain after the next update.

// File: rtl/rr_sched_pkg.sv
package rr_sched_pkg;

   typedef enum logic [2:0] {
      S_IDLE     = 3'd0,
      S_APP_NIL  = 3'd1,
      S_APP_LINK = 3'd2,
      S_POP_RD   = 3'd3,
      S_POP_WAIT = 3'd4
   } sched_state_e;

endpackage

// File: rtl/rr_quantum_timer.sv
module rr_quantum_timer #(
   parameter int QUANTUM_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic clr,
   output logic expired
);

   generate
      if (QUANTUM_TICKS < 1) begin : g_bad_quantum
         $error("QUANTUM_TICKS must be at least 1");
      end

      if (QUANTUM_TICKS == 1) begin : g_single
         logic hit;

         always_ff @(posedge clk) begin
            if (!rst_n)
               hit <= 1'b0;
            else if (clr)
               hit <= 1'b0;
            else if (run && tick)
               hit <= 1'b1;
         end

         assign expired = hit;

         AST_SINGLE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !clr) |=> (hit == $past(hit))); // R10
      end else begin : g_count
         localparam int CW = $clog2(QUANTUM_TICKS + 1);
         localparam logic [CW-1:0] LIMIT = CW'(QUANTUM_TICKS);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (clr)
               cnt <= '0;
            else if (run && tick && cnt != LIMIT)
               cnt <= cnt + 1'b1;
         end

         assign expired = (cnt == LIMIT);

         AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !clr) |=> $stable(cnt)); // R10
         AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (cnt <= CW'(1))); // R5
      end
   endgenerate

endmodule

// File: rtl/rr_enq_slot.sv
module rr_enq_slot #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_id,
   output logic              in_ready,
   input  logic              take,
   output logic              slot_valid,
   output logic [ADDR_W-1:0] slot_id
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_valid <= 1'b0;
         slot_id    <= '0;
      end else if (take) begin
         slot_valid <= 1'b0;
      end else if (in_valid && !slot_valid) begin
         slot_valid <= 1'b1;
         slot_id    <= in_id;
      end
   end

   assign in_ready = !slot_valid;

   AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid && !take) |=> (slot_valid && $stable(slot_id))); // R9
   AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> slot_valid); // R9

endmodule

// File: rtl/rr_list_ctrl.sv
module rr_list_ctrl
   import rr_sched_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drop_req,
   input  logic              expired,
   input  logic              slot_valid,
   input  logic [ADDR_W-1:0] slot_id,
   output logic              timer_clr,
   output logic              slot_take,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              run_valid,
   output logic [ADDR_W-1:0] run_id,
   output logic [ADDR_W-1:0] head_ptr,
   output logic [ADDR_W-1:0] tail_ptr,
   output logic              ctrl_idle
);

   localparam logic [ADDR_W-1:0] NIL = {ADDR_W{1'b1}};

   sched_state_e      st;
   logic [ADDR_W-1:0] head, tail, cur, app;
   logic              cur_v, pop_after;
   logic              empty;

   assign empty = (head == NIL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         head      <= NIL;
         tail      <= NIL;
         cur       <= '0;
         cur_v     <= 1'b0;
         app       <= '0;
         pop_after <= 1'b0;
      end else begin
         case (st)
            S_IDLE: begin
               if (cur_v && drop_req) begin
                  cur_v <= 1'b0;
                  if (!empty) st <= S_POP_RD;
               end else if (cur_v && expired) begin
                  if (!empty) begin
                     app       <= cur;
                     cur_v     <= 1'b0;
                     pop_after <= 1'b1;
                     st        <= S_APP_NIL;
                  end
               end else if (slot_valid) begin
                  app       <= slot_id;
                  pop_after <= 1'b0;
                  st        <= S_APP_NIL;
               end else if (!cur_v && !empty) begin
                  st <= S_POP_RD;
               end
            end
            S_APP_NIL: begin
               if (tail == NIL) begin
                  head <= app;
                  tail <= app;
                  st   <= pop_after ? S_POP_RD : S_IDLE;
               end else begin
                  st <= S_APP_LINK;
               end
            end
            S_APP_LINK: begin
               tail <= app;
               st   <= pop_after ? S_POP_RD : S_IDLE;
            end
            S_POP_RD: begin
               st <= S_POP_WAIT;
            end
            S_POP_WAIT: begin
               cur       <= head;
               cur_v     <= 1'b1;
               head      <= mem_rdata;
               pop_after <= 1'b0;
               if (mem_rdata == NIL) tail <= NIL;
               st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = app;
      mem_wdata = NIL;
      case (st)
         S_APP_NIL: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = app;
            mem_wdata = NIL;
         end
         S_APP_LINK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = tail;
            mem_wdata = app;
         end
         S_POP_RD: begin
            mem_req  = 1'b1;
            mem_addr = head;
         end
         default: ;
      endcase
   end

   assign timer_clr = (st == S_POP_WAIT) ||
                      ((st == S_IDLE) && cur_v && (drop_req || expired));
   assign slot_take = !pop_after &&
                      (((st == S_APP_NIL) && (tail == NIL)) || (st == S_APP_LINK));
   assign run_valid = cur_v;
   assign run_id    = cur;
   assign head_ptr  = head;
   assign tail_ptr  = tail;
   assign ctrl_idle = (st == S_IDLE);

   AST_EMPTY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      ((head_ptr == NIL) == (tail_ptr == NIL))); // R2
   AST_LINK_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_APP_LINK) |=> (tail_ptr == $past(mem_wdata))); // R2
   AST_POP_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_POP_WAIT) |=> (run_valid && run_id == $past(head_ptr))); // R3
   AST_KEEP_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_IDLE) && run_valid && !drop_req && expired && (head_ptr == NIL))
      |=> (run_valid && $stable(run_id) && !mem_we)); // R5
   AST_BLOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_IDLE) && run_valid && drop_req) |=> !run_valid); // R6
   AST_DROP_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_IDLE) && !run_valid && drop_req && !slot_valid && (head_ptr == NIL))
      |=> (!run_valid && $stable(head_ptr) && $stable(tail_ptr))); // R8

endmodule

// File: rtl/rr_task_scheduler.sv
module rr_task_scheduler #(
   parameter int ADDR_W        = 6,
   parameter int QUANTUM_TICKS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              enq_valid,
   input  logic [ADDR_W-1:0] enq_id,
   output logic              enq_ready,
   input  logic              block_req,
   input  logic              term_req,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [ADDR_W-1:0] mem_wdata,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              run_valid,
   output logic [ADDR_W-1:0] run_id,
   output logic [ADDR_W-1:0] head_ptr,
   output logic [ADDR_W-1:0] tail_ptr,
   output logic              busy
);

   localparam logic [ADDR_W-1:0] NIL = {ADDR_W{1'b1}};

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("ADDR_W must be at least 2");
      end
   endgenerate

   logic              expired, timer_clr, slot_take, slot_valid, ctrl_idle;
   logic [ADDR_W-1:0] slot_id;

   rr_quantum_timer #(.QUANTUM_TICKS(QUANTUM_TICKS)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .run     (run_valid),
      .clr     (timer_clr),
      .expired (expired)
   );

   rr_enq_slot #(.ADDR_W(ADDR_W)) i_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (enq_valid),
      .in_id      (enq_id),
      .in_ready   (enq_ready),
      .take       (slot_take),
      .slot_valid (slot_valid),
      .slot_id    (slot_id)
   );

   rr_list_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .drop_req   (block_req || term_req),
      .expired    (expired),
      .slot_valid (slot_valid),
      .slot_id    (slot_id),
      .timer_clr  (timer_clr),
      .slot_take  (slot_take),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .run_valid  (run_valid),
      .run_id     (run_id),
      .head_ptr   (head_ptr),
      .tail_ptr   (tail_ptr),
      .ctrl_idle  (ctrl_idle)
   );

   assign busy = !ctrl_idle || slot_valid || (run_valid && expired) ||
                 (!run_valid && head_ptr != NIL);

   AST_WRITE_IS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req); // R2
   AST_NO_NULL_WRITE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr != NIL)); // R2

endmodule

// File: tb/test_rr_task_scheduler.sv
module test_rr_task_scheduler;

   localparam int AW  = 6;
   localparam int Q   = 4;
   localparam int NID = 16;
   localparam logic [AW-1:0] NIL = {AW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0, enq_valid = 1'b0, block_req = 1'b0, term_req = 1'b0;
   logic [AW-1:0] enq_id = '0;
   logic          enq_ready, mem_req, mem_we, run_valid, busy;
   logic [AW-1:0] mem_addr, mem_wdata, mem_rdata, run_id, head_ptr, tail_ptr;

   int checks = 0;
   int errors = 0;
   int writes = 0;

   logic [AW-1:0] mem [64];

   int  mq[$];
   int  mcur = 0;
   bit  mcurv = 0;
   int  mtcnt = 0;
   bit  mused [NID];

   always #4 clk = ~clk;

   rr_task_scheduler #(.ADDR_W(AW), .QUANTUM_TICKS(Q)) i_rr_task_scheduler (
      .clk(clk), .rst_n(rst_n), .tick(tick), .enq_valid(enq_valid), .enq_id(enq_id),
      .enq_ready(enq_ready), .block_req(block_req), .term_req(term_req),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .run_valid(run_valid), .run_id(run_id),
      .head_ptr(head_ptr), .tail_ptr(tail_ptr), .busy(busy)
   );

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            writes <= writes + 1;
         end else begin
            mem_rdata <= mem[mem_addr];
         end
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // model steps
   function automatic void m_dispatch();
      if (!mcurv && mq.size() > 0) begin
         mcur  = mq.pop_front();
         mcurv = 1;
         mtcnt = 0;
      end
   endfunction

   function automatic void m_enq(int id);
      mq.push_back(id);
      mused[id] = 1;
      m_dispatch();
   endfunction

   function automatic void m_tick();
      if (mcurv) begin
         mtcnt++;
         if (mtcnt == Q) begin
            mtcnt = 0;
            if (mq.size() > 0) begin
               mq.push_back(mcur);
               mcur = mq.pop_front();
            end
         end
      end
   endfunction

   function automatic void m_drop();
      if (mcurv) begin
         mused[mcur] = 0;
         mcurv = 0;
         mtcnt = 0;
         m_dispatch();
      end
   endfunction

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic check_state(string req);
      int p;
      chk(req, "run_valid", int'(run_valid), int'(mcurv));
      if (mcurv) chk(req, "run_id", int'(run_id), mcur);
      chk(req, "head_ptr", int'(head_ptr), mq.size() > 0 ? mq[0] : int'(NIL));
      chk(req, "tail_ptr", int'(tail_ptr), mq.size() > 0 ? mq[$] : int'(NIL));
      // R2: chain walked in memory matches arrival order
      p = int'(head_ptr);
      for (int k = 0; k < mq.size(); k++) begin
         chk("R2", "chain entry", p, mq[k]);
         p = int'(mem[p[AW-1:0]]);
      end
      chk("R2", "chain end", p, int'(NIL));
   endtask

   task automatic do_enq(int id, string req);
      @(negedge clk);
      while (!enq_ready) @(negedge clk);
      enq_valid = 1'b1;
      enq_id    = AW'(id);
      @(negedge clk);
      enq_valid = 1'b0;
      m_enq(id);
      wait_idle();
      check_state(req);
   endtask

   task automatic do_tick(string req);
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      m_tick();
      wait_idle();
      check_state(req);
   endtask

   task automatic do_drop(bit term, string req);
      @(negedge clk);
      if (term) term_req = 1'b1; else block_req = 1'b1;
      @(negedge clk);
      term_req  = 1'b0;
      block_req = 1'b0;
      m_drop();
      wait_idle();
      check_state(req);
   endtask

   function automatic int pick_free();
      int s = int'($urandom % NID);
      for (int k = 0; k < NID; k++) begin
         int c = (s + k) % NID;
         if (!mused[c]) return c;
      end
      return -1;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired R1 actual 0 expected 1");
      summary();
      $finish;
   end

   initial begin
      int w0;
      void'($urandom(32'd1234));
      for (int i = 0; i < 64; i++) mem[i] = '0;
      for (int i = 0; i < NID; i++) mused[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "run_valid", int'(run_valid), 0);
      chk("R1", "head_ptr", int'(head_ptr), int'(NIL));
      chk("R1", "tail_ptr", int'(tail_ptr), int'(NIL));
      chk("R1", "enq_ready", int'(enq_ready), 1);
      chk("R1", "busy", int'(busy), 0);

      // R10: ticks with nothing running are not counted
      for (int i = 0; i < 3; i++) do_tick("R10");
      do_enq(3, "R3");
      do_enq(7, "R2");
      for (int i = 0; i < Q - 1; i++) do_tick("R10");
      chk("R10", "still first task", int'(run_id), 3);
      do_tick("R4");
      chk("R4", "rotated to second", int'(run_id), 7);

      // R6: block hands over at once, R5: empty-list expiry keeps task
      do_drop(1'b0, "R6");
      chk("R6", "head task runs", int'(run_id), 3);
      w0 = writes;
      for (int i = 0; i < Q; i++) do_tick("R5");
      chk("R5", "same task", int'(run_id), 3);
      chk("R5", "no memory writes", writes - w0, 0);
      do_tick("R5");
      chk("R5", "count restarted", int'(run_id), 3);

      // R9: back-to-back enqueues
      @(negedge clk);
      enq_valid = 1'b1;
      enq_id    = AW'(9);
      @(negedge clk);
      m_enq(9);
      enq_id = AW'(11);
      chk("R9", "enq_ready held low", int'(enq_ready), 0);
      while (!enq_ready) @(negedge clk);
      @(negedge clk);
      enq_valid = 1'b0;
      m_enq(11);
      wait_idle();
      check_state("R9");

      // R9: enqueue arriving during a rotation lands after the rotated task
      for (int i = 0; i < Q - 2; i++) do_tick("R4");
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick      = 1'b0;
      enq_valid = 1'b1;
      enq_id    = AW'(12);
      @(negedge clk);
      enq_valid = 1'b0;
      m_tick();
      m_enq(12);
      wait_idle();
      check_state("R9");

      // R7: terminated task disappears
      do_drop(1'b1, "R7");
      while (mcurv) do_drop(1'b1, "R7");
      // R8: drops with nothing running have no effect
      do_drop(1'b0, "R8");
      do_drop(1'b1, "R8");
      chk("R8", "run_valid", int'(run_valid), 0);

      // random mix
      for (int n = 0; n < 600; n++) begin
         int r = int'($urandom % 10);
         if (r < 4) begin
            int id = pick_free();
            if (id >= 0) do_enq(id, "R2");
            else do_tick("R4");
         end else if (r < 8) begin
            do_tick("R4");
         end else if (r == 8) begin
            do_drop(1'b0, "R6");
         end else begin
            do_drop(1'b1, "R7");
         end
      end

      summary();
      $finish;
   end

endmodule